// File: doc/BRIEF.md
# CAN Bus-Off Status and Interrupt Unit

This unit keeps the fault-confinement state of a CAN controller together with a sticky bus-off interrupt flag and the mask that gates it onto a single interrupt request line. The protocol engine reports entry into bus off through a one-cycle event input. It reports a return to error active through a second event input. Software sees the state through three small registers on a simple single-cycle register interface: a module-configuration word, a control word and a status word.

A self-clearing soft-reset bit in the module-configuration word puts the unit through a soft reset of fixed length. During that window the fault state is forced to error active and the bus-off flag is held clear. Events from the protocol engine are ignored for the whole window. When the bit drops, nothing reinstates the old state, so the flag stays clear and the fault field does not briefly return to bus off. The interrupt mask lives in the control word, and a soft reset leaves it alone.

Register map (8-bit data, 2-bit address):

| Address | Word | Bits |
|---|---|---|
| 0 | module configuration | bit 0: soft reset (write 1 to start, reads 1 while busy) |
| 1 | control | bit 0: bus-off interrupt mask |
| 2 | status | bits 1:0: fault state (read only); bit 2: bus-off flag (write 1 to clear) |

All other bits read 0.

Top module: `can_busoff_stat`

## Requirements
- R1: After hard reset the fault field reads 0b00, the flag, the mask and the soft-reset bit read 0, and `irq` is low.
- R2: A `busoff_evt` pulse outside soft reset makes the fault field read 0b11 (bus off) and sets the flag (status bit 2), both visible from the next cycle.
- R3: An `active_evt` pulse outside soft reset makes the fault field read 0b00 and leaves the flag unchanged. If both events arrive together, bus off wins.
- R4: `irq` is high exactly when the flag is set and the mask (control bit 0) is 1.
- R5: Writing 1 to status bit 2 clears the flag. Writing 0 there changes nothing, and writes to status bits 1:0 do not change the fault field.
- R6: When a bus-off event and a write-1-to-clear of the flag fall in the same cycle, the flag stays set.
- R7: Writing 1 to module-configuration bit 0 starts a soft reset. The bit reads 1 for exactly SRST_CYCLES cycles and then 0. Writing 1 again while it is busy does not extend the window.
- R8: A soft reset sets the fault field to 0b00 and clears the flag. After the bit clears, the flag stays 0 and the fault field stays 0b00 until a new event arrives.
- R9: Bus-off and error-active events that arrive during a soft reset have no effect.
- R10: A soft reset leaves the mask unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | peripheral clock |
| rst_n | input | 1 | asynchronous active-low hard reset |
| reg_wr | input | 1 | register write strobe |
| reg_addr | input | 2 | register address |
| reg_wdata | input | DATA_W | write data |
| reg_rdata | output | DATA_W | read data of the addressed word |
| busoff_evt | input | 1 | one-cycle pulse: the controller entered bus off |
| active_evt | input | 1 | one-cycle pulse: the controller recovered to error active |
| irq | output | 1 | bus-off interrupt request |

## Verification
The hardest case to reach is the end of a soft reset that started from bus off with the interrupt enabled. The window closes on a count of cycles, not on any port event, so the bench must drive the unit into bus off and enable the mask before it starts the reset. It also fires both kinds of event while the window is open. The bench then counts the cycles for which the busy bit reads 1 and checks the flag, the fault field and `irq` on every following cycle for a stretch with no events. Any reappearance of bus off would show there.

// File: rtl/can_bo_pkg.sv
package can_bo_pkg;

  localparam int ADDR_W = 2;

  localparam logic [ADDR_W-1:0] ADDR_MCFG = 2'd0;
  localparam logic [ADDR_W-1:0] ADDR_CTRL = 2'd1;
  localparam logic [ADDR_W-1:0] ADDR_STAT = 2'd2;

  localparam int BIT_SRST  = 0;
  localparam int BIT_MASK  = 0;
  localparam int BIT_FLAG  = 2;
  localparam int FAULT_LSB = 0;
  localparam int FAULT_W   = 2;

  typedef enum logic [FAULT_W-1:0] {
    FC_ACTIVE  = 2'b00,
    FC_PASSIVE = 2'b01,
    FC_RSVD    = 2'b10,
    FC_BUSOFF  = 2'b11
  } fault_e;

endpackage

// File: rtl/can_bo_srst.sv
module can_bo_srst #(
  parameter int SRST_CYCLES = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start_i,
  output logic busy_o
);
  localparam int CNT_W = $clog2(SRST_CYCLES + 1);
  localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(SRST_CYCLES - 1);

  logic             busy_q, busy_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;

  always_comb begin
    busy_d = busy_q;
    cnt_d  = cnt_q;
    cnt_en = 1'b0;
    if (!busy_q && start_i) begin
      busy_d = 1'b1;
      cnt_d  = CNT_LOAD;
      cnt_en = 1'b1;
    end else if (busy_q) begin
      cnt_en = 1'b1;
      if (cnt_q == '0) begin
        busy_d = 1'b0;
      end else begin
        cnt_d = cnt_q - 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
    end else if (cnt_en) begin
      busy_q <= busy_d;
      cnt_q  <= cnt_d;
    end
  end

  assign busy_o = busy_q;

  // Checker: length of the busy window, counted independently.
  logic [CNT_W:0] chk_len_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chk_len_q <= '0;
    else if (busy_q) chk_len_q <= chk_len_q + 1'b1;
    else chk_len_q <= '0;
  end

  assert_window_len_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy_q) |-> (chk_len_q == (CNT_W+1)'(SRST_CYCLES)));

  assert_window_bound_R7: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q |-> (chk_len_q < (CNT_W+1)'(SRST_CYCLES)));

endmodule

// File: rtl/can_bo_fault.sv
module can_bo_fault
  import can_bo_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   busoff_evt_i,
  input  logic   active_evt_i,
  input  logic   flag_w1c_i,
  input  logic   srst_start_i,
  input  logic   srst_busy_i,
  output fault_e fault_o,
  output logic   flag_o
);
  fault_e fault_q, fault_d;
  logic   flag_q, flag_d;
  logic   hold;
  logic   upd_en;

  assign hold = srst_start_i | srst_busy_i;

  always_comb begin
    fault_d = fault_q;
    flag_d  = flag_q;
    if (hold) begin
      fault_d = FC_ACTIVE;
      flag_d  = 1'b0;
    end else begin
      if (busoff_evt_i) begin
        fault_d = FC_BUSOFF;
      end else if (active_evt_i) begin
        fault_d = FC_ACTIVE;
      end
      if (busoff_evt_i) begin
        flag_d = 1'b1;
      end else if (flag_w1c_i) begin
        flag_d = 1'b0;
      end
    end
  end

  assign upd_en = hold | busoff_evt_i | active_evt_i | flag_w1c_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fault_q <= FC_ACTIVE;
      flag_q  <= 1'b0;
    end else if (upd_en) begin
      fault_q <= fault_d;
      flag_q  <= flag_d;
    end
  end

  assign fault_o = fault_q;
  assign flag_o  = flag_q;

  assert_busoff_sets_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (busoff_evt_i && !hold) |=> (fault_q == FC_BUSOFF && flag_q));

  assert_busoff_beats_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (busoff_evt_i && flag_w1c_i && !hold) |=> flag_q);

  assert_clean_exit_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(srst_busy_i) |-> (fault_q == FC_ACTIVE && !flag_q));

  assert_no_busoff_in_srst_R9: assert property (@(posedge clk) disable iff (!rst_n)
    srst_busy_i |-> (fault_q != FC_BUSOFF && !flag_q));

endmodule

// File: rtl/can_bo_regif.sv
module can_bo_regif
  import can_bo_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  fault_e            fault_i,
  input  logic              flag_i,
  input  logic              srst_busy_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              mask_o,
  output logic              srst_start_o,
  output logic              flag_w1c_o
);
  logic mask_q, mask_d, mask_en;
  logic wr_mcfg, wr_ctrl, wr_stat;

  assign wr_mcfg = wr_i && (addr_i == ADDR_MCFG);
  assign wr_ctrl = wr_i && (addr_i == ADDR_CTRL);
  assign wr_stat = wr_i && (addr_i == ADDR_STAT);

  assign srst_start_o = wr_mcfg && wdata_i[BIT_SRST] && !srst_busy_i;
  assign flag_w1c_o   = wr_stat && wdata_i[BIT_FLAG];

  always_comb begin
    mask_en = wr_ctrl;
    mask_d  = wdata_i[BIT_MASK];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mask_q <= 1'b0;
    else if (mask_en) mask_q <= mask_d;
  end

  assign mask_o = mask_q;

  always_comb begin
    rdata_o = '0;
    case (addr_i)
      ADDR_MCFG: rdata_o[BIT_SRST] = srst_busy_i;
      ADDR_CTRL: rdata_o[BIT_MASK] = mask_q;
      ADDR_STAT: begin
        rdata_o[FAULT_LSB +: FAULT_W] = fault_i;
        rdata_o[BIT_FLAG]             = flag_i;
      end
      default:   rdata_o = '0;
    endcase
  end

  assert_mask_kept_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_ctrl |=> $stable(mask_q));

endmodule

// File: rtl/can_busoff_stat.sv
module can_busoff_stat #(
  parameter int DATA_W      = 8,
  parameter int SRST_CYCLES = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [1:0]        reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  input  logic              busoff_evt,
  input  logic              active_evt,
  output logic              irq
);
  import can_bo_pkg::*;

  fault_e fault;
  logic   flag, mask, srst_start, srst_busy, flag_w1c;

  can_bo_regif #(.DATA_W(DATA_W)) u_regif (
    .clk          (clk),
    .rst_n        (rst_n),
    .wr_i         (reg_wr),
    .addr_i       (reg_addr),
    .wdata_i      (reg_wdata),
    .fault_i      (fault),
    .flag_i       (flag),
    .srst_busy_i  (srst_busy),
    .rdata_o      (reg_rdata),
    .mask_o       (mask),
    .srst_start_o (srst_start),
    .flag_w1c_o   (flag_w1c)
  );

  can_bo_srst #(.SRST_CYCLES(SRST_CYCLES)) u_srst (
    .clk     (clk),
    .rst_n   (rst_n),
    .start_i (srst_start),
    .busy_o  (srst_busy)
  );

  can_bo_fault u_fault (
    .clk          (clk),
    .rst_n        (rst_n),
    .busoff_evt_i (busoff_evt),
    .active_evt_i (active_evt),
    .flag_w1c_i   (flag_w1c),
    .srst_start_i (srst_start),
    .srst_busy_i  (srst_busy),
    .fault_o      (fault),
    .flag_o       (flag)
  );

  assign irq = flag & mask;

  assert_irq_needs_flag_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> ($rose(flag) || $rose(mask)));

endmodule

// File: tb/can_busoff_stat_bench.sv
module can_busoff_stat_bench;
  localparam int DW   = 8;
  localparam int NSRC = 4;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          reg_wr = 1'b0;
  logic [1:0]    reg_addr = 2'd0;
  logic [DW-1:0] reg_wdata = '0;
  logic [DW-1:0] reg_rdata;
  logic          busoff_evt = 1'b0;
  logic          active_evt = 1'b0;
  logic          irq;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #4 clk = ~clk;

  can_busoff_stat #(.DATA_W(DW), .SRST_CYCLES(NSRC)) u_can_busoff_stat (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .busoff_evt(busoff_evt),
    .active_evt(active_evt), .irq(irq)
  );

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [DW-1:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0; reg_wdata = '0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [DW-1:0] d);
    reg_addr = a;
    #1;
    d = reg_rdata;
  endtask

  task automatic pulse(input bit bo, input bit ea);
    @(negedge clk);
    busoff_evt = bo; active_evt = ea;
    @(negedge clk);
    busoff_evt = 1'b0; active_evt = 1'b0;
  endtask

  task automatic hard_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic t_reset_state();
    logic [DW-1:0] v;
    rd(2'd2, v); check("R1 status", int'(v), 0);
    rd(2'd1, v); check("R1 ctrl", int'(v), 0);
    rd(2'd0, v); check("R1 mcfg", int'(v), 0);
    check("R1 irq", int'(irq), 0);
  endtask

  task automatic t_busoff_and_irq();
    logic [DW-1:0] v;
    pulse(1'b1, 1'b0);
    rd(2'd2, v); check("R2 status after busoff", int'(v), 7);
    check("R4 irq masked", int'(irq), 0);
    wr(2'd1, 8'h01);
    check("R4 irq enabled", int'(irq), 1);
    pulse(1'b0, 1'b1);
    rd(2'd2, v); check("R3 active keeps flag", int'(v), 4);
    wr(2'd2, 8'h03);
    rd(2'd2, v); check("R5 write 0 to flag and fault bits", int'(v), 4);
    wr(2'd2, 8'h04);
    rd(2'd2, v); check("R5 w1c clears flag", int'(v), 0);
    check("R4 irq off after clear", int'(irq), 0);
    pulse(1'b1, 1'b1);
    rd(2'd2, v); check("R3 busoff wins", int'(v), 7);
  endtask

  task automatic t_same_cycle();
    logic [DW-1:0] v;
    wr(2'd2, 8'h04);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = 2'd2; reg_wdata = 8'h04; busoff_evt = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0; reg_wdata = '0; busoff_evt = 1'b0;
    rd(2'd2, v); check("R6 event beats clear", int'(v), 7);
  endtask

  task automatic t_soft_reset();
    logic [DW-1:0] v;
    int n;
    wr(2'd1, 8'h01);
    pulse(1'b1, 1'b0);
    check("R4 irq before soft reset", int'(irq), 1);
    wr(2'd0, 8'h01);
    n = 0;
    for (int k = 0; k < 100; k++) begin
      rd(2'd0, v);
      if (v[0] !== 1'b1) break;
      n++;
      if (n == 1) begin
        rd(2'd2, v); check("R8 state forced in window", int'(v), 0);
        busoff_evt = 1'b1;
      end else if (n == 2) begin
        busoff_evt = 1'b0; active_evt = 1'b1;
        reg_wr = 1'b1; reg_addr = 2'd0; reg_wdata = 8'h01;
      end else begin
        active_evt = 1'b0; reg_wr = 1'b0; reg_wdata = '0;
      end
      @(negedge clk);
    end
    busoff_evt = 1'b0; active_evt = 1'b0; reg_wr = 1'b0;
    check("R7 window length", n, NSRC);
    rd(2'd2, v); check("R9 events ignored in window", int'(v), 0);
    for (int k = 0; k < 8; k++) begin
      rd(2'd2, v); check("R8 stays clean after exit", int'(v), 0);
      check("R8 irq stays low", int'(irq), 0);
      @(negedge clk);
    end
    rd(2'd1, v); check("R10 mask kept", int'(v), 1);
    pulse(1'b1, 1'b0);
    rd(2'd2, v); check("R2 busoff works after soft reset", int'(v), 7);
    check("R4 irq after soft reset", int'(irq), 1);
  endtask

  initial begin
    hard_reset();
    t_reset_state();
    t_busoff_and_irq();
    t_same_cycle();
    t_soft_reset();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

endmodule